// File: doc/BRIEF.md
# Work-Group Admission Gate

This block guards the entry to one compute cluster. Work groups arrive as descriptors that carry a thread count, a register count per thread and a scratchpad byte count. They wait in a small first-in first-out queue, and no resources are held for them while they wait. On each clock the gate looks at the oldest waiting group. It admits that group only if four pools all have room for it at once: block slots, warp slots, scratchpad bytes and registers. On admission the gate reserves the group's share of each pool and reports the slot number it gave the group.

Active groups finish in any order. A finish event names a slot and returns exactly what that slot reserved. The gate drives its occupancy counters out on ports, so surrounding logic or a performance model can see how full the cluster is. A descriptor that could never be served is refused at the queue input.

Top module: `blk_admit`

## Requirements
- R1: No more than MAX_BLOCKS (32) groups are active at once. A group that would exceed this stays queued.
- R2: A group needs ceil(threads / 32) warps. The active warp total never exceeds MAX_WARPS (64), and `act_warps` reports that total.
- R3: Each admitted group takes its byte count from a 65536-byte scratchpad pool. `free_scratch` shows the bytes not reserved.
- R4: Each admitted group takes warps × 32 × regs-per-thread registers from a 65536-entry pool. `free_regs` shows the registers not reserved.
- R5: A descriptor is refused in the cycle it is offered. This happens when regs-per-thread is above 255, the thread count is 0 or above 1024, the byte count is above 65536, or its warp or register need exceeds a whole pool. A refused descriptor raises `push_bad` and is not queued.
- R6: The head group is admitted only when all four checks pass. `adm_valid` then pulses for one cycle, on the clock edge after the head reaches the queue front, and `adm_slot` carries the lowest-numbered free slot.
- R7: Admission follows queue order. A head that does not fit holds back every group behind it, even groups that would fit.
- R8: A release of an active slot, in any order, returns exactly that group's warps, bytes and registers and its block slot. A release of an inactive slot changes nothing.
- R9: A release and an admission may fall on the same edge. The release is applied first, so the slot and resources it frees can be used by the group admitted on that edge.
- R10: After reset no group is active, both pools read full, and the queue is empty.
- R11: The queue holds QDEPTH descriptors. `push_ready` is low while the queue is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Descriptor offered this cycle |
| push_thr | input | 11 | Thread count of the offered group |
| push_rpt | input | 9 | Registers per thread of the offered group |
| push_scr | input | 17 | Scratchpad bytes of the offered group |
| push_ready | output | 1 | Queue has space |
| push_bad | output | 1 | Offered descriptor refused |
| adm_valid | output | 1 | A group was admitted on the last edge |
| adm_slot | output | 5 | Slot given to the admitted group |
| rel_valid | input | 1 | Group completion event |
| rel_slot | input | 5 | Slot of the completed group |
| act_blocks | output | 6 | Active group count |
| act_warps | output | 7 | Active warp count |
| free_scratch | output | 17 | Unreserved scratchpad bytes |
| free_regs | output | 17 | Unreserved registers |
| q_count | output | 4 | Descriptors waiting |

## Verification
The bench keeps the default pool sizes of 32 blocks, 64 warps and 65536 bytes and registers, so each limit is hit by a realistic group mix: 33 one-warp groups, two 1024-thread groups, or a 255-register group. The queue depth is cut to 4. That lets a stalled head fill the queue within a few pushes, which exercises the full-queue condition next to head-of-line blocking. Releases arrive on the same edge as a pending admission, so slot reuse on that edge is seen directly on `adm_slot`.

// File: rtl/blk_admit.sv
`timescale 1ns/1ps
module blk_admit #(
  parameter int MAX_BLOCKS    = 32,
  parameter int MAX_WARPS     = 64,
  parameter int WARP_SIZE     = 32,
  parameter int SCRATCH_BYTES = 65536,
  parameter int REG_TOTAL     = 65536,
  parameter int MAX_RPT       = 255,
  parameter int MAX_THREADS   = 1024,
  parameter int QDEPTH        = 8,
  localparam int TW  = $clog2(MAX_THREADS + 1),
  localparam int RPW = $clog2(MAX_RPT + 1) + 1,
  localparam int SW  = $clog2(SCRATCH_BYTES + 1),
  localparam int GW  = $clog2(REG_TOTAL + 1),
  localparam int BW  = $clog2(MAX_BLOCKS + 1),
  localparam int SLW = $clog2(MAX_BLOCKS),
  localparam int WW  = $clog2(MAX_WARPS + 1),
  localparam int QCW = $clog2(QDEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_valid,
  input  logic [TW-1:0]  push_thr,
  input  logic [RPW-1:0] push_rpt,
  input  logic [SW-1:0]  push_scr,
  output logic           push_ready,
  output logic           push_bad,
  output logic           adm_valid,
  output logic [SLW-1:0] adm_slot,
  input  logic           rel_valid,
  input  logic [SLW-1:0] rel_slot,
  output logic [BW-1:0]  act_blocks,
  output logic [WW-1:0]  act_warps,
  output logic [SW-1:0]  free_scratch,
  output logic [GW-1:0]  free_regs,
  output logic [QCW-1:0] q_count
);
  localparam int QPW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  logic [31:0] in_warps, in_regs;
  logic        accept;

  assign in_warps = (32'(push_thr) + 32'(WARP_SIZE) - 32'd1) / 32'(WARP_SIZE);
  assign in_regs  = in_warps * 32'(WARP_SIZE) * 32'(push_rpt);
  assign push_bad = push_valid && (32'(push_rpt) > 32'(MAX_RPT) || push_thr == '0 ||
                    32'(push_thr) > 32'(MAX_THREADS) || 32'(push_scr) > 32'(SCRATCH_BYTES) ||
                    in_warps > 32'(MAX_WARPS) || in_regs > 32'(REG_TOTAL));
  assign push_ready = 32'(q_count) < 32'(QDEPTH);
  assign accept = push_valid && !push_bad && push_ready;

  logic [WW-1:0]  q_w [QDEPTH];
  logic [SW-1:0]  q_s [QDEPTH];
  logic [GW-1:0]  q_g [QDEPTH];
  logic [QPW-1:0] wp, rp;

  logic [WW-1:0]  s_w [MAX_BLOCKS];
  logic [SW-1:0]  s_s [MAX_BLOCKS];
  logic [GW-1:0]  s_g [MAX_BLOCKS];
  logic [MAX_BLOCKS-1:0] live, live_r;

  logic        rel_ok, admit, found;
  logic [31:0] blk_r, warp_r, scr_r, reg_r;
  logic [SLW-1:0] pick;

  assign rel_ok = rel_valid && 32'(rel_slot) < 32'(MAX_BLOCKS) && live[rel_slot];
  assign blk_r  = 32'(act_blocks) - (rel_ok ? 32'd1 : 32'd0);
  assign warp_r = 32'(act_warps) - (rel_ok ? 32'(s_w[rel_slot]) : 32'd0);
  assign scr_r  = 32'(free_scratch) + (rel_ok ? 32'(s_s[rel_slot]) : 32'd0);
  assign reg_r  = 32'(free_regs) + (rel_ok ? 32'(s_g[rel_slot]) : 32'd0);

  always_comb begin
    live_r = live;
    if (rel_ok) live_r[rel_slot] = 1'b0;
    found = 1'b0;
    pick  = '0;
    for (int i = MAX_BLOCKS - 1; i >= 0; i--) begin
      if (!live_r[i]) begin
        found = 1'b1;
        pick  = SLW'(i);
      end
    end
  end

  assign admit = q_count != '0 && found && blk_r < 32'(MAX_BLOCKS) &&
                 32'(q_w[rp]) + warp_r <= 32'(MAX_WARPS) &&
                 32'(q_s[rp]) <= scr_r && 32'(q_g[rp]) <= reg_r;

  function automatic logic [QPW-1:0] bump(input logic [QPW-1:0] p);
    return (32'(p) == 32'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_blocks   <= '0;
      act_warps    <= '0;
      free_scratch <= SW'(SCRATCH_BYTES);
      free_regs    <= GW'(REG_TOTAL);
      live         <= '0;
      adm_valid    <= 1'b0;
      adm_slot     <= '0;
      wp           <= '0;
      rp           <= '0;
      q_count      <= '0;
    end else begin
      act_blocks   <= BW'(blk_r + (admit ? 32'd1 : 32'd0));
      act_warps    <= WW'(warp_r + (admit ? 32'(q_w[rp]) : 32'd0));
      free_scratch <= SW'(scr_r - (admit ? 32'(q_s[rp]) : 32'd0));
      free_regs    <= GW'(reg_r - (admit ? 32'(q_g[rp]) : 32'd0));
      live         <= admit ? (live_r | (MAX_BLOCKS'(1) << pick)) : live_r;
      adm_valid    <= admit;
      if (admit) adm_slot <= pick;
      if (accept) wp <= bump(wp);
      if (admit)  rp <= bump(rp);
      q_count <= QCW'(32'(q_count) + (accept ? 32'd1 : 32'd0) - (admit ? 32'd1 : 32'd0));
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      q_w[wp] <= WW'(in_warps);
      q_s[wp] <= push_scr;
      q_g[wp] <= GW'(in_regs);
    end
    if (admit) begin
      s_w[pick] <= q_w[rp];
      s_s[pick] <= q_s[rp];
      s_g[pick] <= q_g[rp];
    end
  end
endmodule

// File: rtl/blk_admit_chk.sv
`timescale 1ns/1ps
module blk_admit_chk #(
  parameter int MAX_BLOCKS = 32, MAX_WARPS = 64, SCRATCH_BYTES = 65536, REG_TOTAL = 65536,
  parameter int BW = 6, WW = 7, SW = 17, GW = 17, QCW = 4
) (
  input logic clk, rst_n, push_valid, push_bad, adm_valid, rel_valid,
  input logic [BW-1:0] act_blocks,
  input logic [WW-1:0] act_warps,
  input logic [SW-1:0] free_scratch,
  input logic [GW-1:0] free_regs,
  input logic [QCW-1:0] q_count
);
  a_r1_block_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(act_blocks) <= 32'(MAX_BLOCKS));
  a_r2_warp_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(act_warps) <= 32'(MAX_WARPS));
  a_r3_scratch_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(free_scratch) <= 32'(SCRATCH_BYTES));
  a_r4_reg_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(free_regs) <= 32'(REG_TOTAL));
  a_r5_refused_not_queued: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && push_bad |=> q_count <= $past(q_count));
  a_r6_admit_from_queue: assert property (@(posedge clk) disable iff (!rst_n)
    adm_valid |-> $past(q_count) != '0 && act_blocks != '0);
  a_r8_no_free_without_release: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_valid |=> free_scratch <= $past(free_scratch) && free_regs <= $past(free_regs) &&
                   act_blocks >= $past(act_blocks));
endmodule

bind blk_admit blk_admit_chk #(
  .MAX_BLOCKS(MAX_BLOCKS), .MAX_WARPS(MAX_WARPS), .SCRATCH_BYTES(SCRATCH_BYTES),
  .REG_TOTAL(REG_TOTAL), .BW(BW), .WW(WW), .SW(SW), .GW(GW), .QCW(QCW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_bad(push_bad),
  .adm_valid(adm_valid), .rel_valid(rel_valid), .act_blocks(act_blocks),
  .act_warps(act_warps), .free_scratch(free_scratch), .free_regs(free_regs),
  .q_count(q_count)
);

// File: tb/sim_blk_admit.sv
`timescale 1ns/1ps
module sim_blk_admit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 1'b0, rel_valid = 1'b0;
  logic [10:0] push_thr = '0;
  logic [8:0]  push_rpt = '0;
  logic [16:0] push_scr = '0;
  logic [4:0]  rel_slot = '0;
  logic push_ready, push_bad, adm_valid;
  logic [4:0] adm_slot;
  logic [5:0] act_blocks;
  logic [6:0] act_warps;
  logic [16:0] free_scratch, free_regs;
  logic [3:0] q_count;

  int checks = 0, errors = 0, adm_n = 0, last_slot = -1;
  bit done = 0;

  always #10 clk = ~clk;

  blk_admit #(.QDEPTH(4)) u0 (.*);

  always @(posedge clk) begin
    #5;
    if (adm_valid) begin adm_n++; last_slot = int'(adm_slot); end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int thr, input int rpt, input int scr);
    @(negedge clk);
    push_valid = 1; push_thr = 11'(thr); push_rpt = 9'(rpt); push_scr = 17'(scr);
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic release_slot(input int s);
    @(negedge clk);
    rel_valid = 1; rel_slot = 5'(s);
    @(negedge clk);
    rel_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pools(input string req, input int b, input int w, input int s, input int g);
    chk({req, " blocks"}, int'(act_blocks), b);
    chk({req, " warps"}, int'(act_warps), w);
    chk({req, " scratch"}, int'(free_scratch), s);
    chk({req, " regs"}, int'(free_regs), g);
  endtask

  task automatic t_reset;
    expect_pools("R10", 0, 0, 65536, 65536);
    chk("R10 queue", int'(q_count), 0);
    chk("R11 ready", int'(push_ready), 1);
  endtask

  task automatic t_basic;
    int n0 = adm_n;
    push(64, 32, 2048);
    idle(1);
    chk("R6 admitted", adm_n - n0, 1);
    chk("R6 slot", last_slot, 0);
    expect_pools("R2 R3 R4 basic", 1, 2, 63488, 63488);
    release_slot(0);
    expect_pools("R8 basic release", 0, 0, 65536, 65536);
  endtask

  task automatic t_round;
    push(33, 10, 0);
    idle(1);
    expect_pools("R2 R4 rounding", 1, 2, 65536, 65536 - 640);
    release_slot(0);
  endtask

  task automatic t_reject;
    int n0 = adm_n;
    @(negedge clk);
    push_valid = 1; push_thr = 11'd32; push_rpt = 9'd256; push_scr = '0;
    #1 chk("R5 rpt above limit", int'(push_bad), 1);
    @(negedge clk);
    push_thr = 11'd0; push_rpt = 9'd8;
    #1 chk("R5 zero threads", int'(push_bad), 1);
    @(negedge clk);
    push_valid = 0;
    idle(2);
    chk("R5 not queued", int'(q_count), 0);
    chk("R5 no admit", adm_n - n0, 0);
    expect_pools("R5 pools", 0, 0, 65536, 65536);
  endtask

  task automatic t_blocks;
    for (int i = 0; i < 33; i++) push(32, 1, 0);
    idle(2);
    chk("R1 block cap", int'(act_blocks), 32);
    chk("R1 waiting", int'(q_count), 1);
    release_slot(5);
    chk("R9 reused slot", last_slot, 5);
    chk("R9 blocks", int'(act_blocks), 32);
    chk("R9 queue drained", int'(q_count), 0);
    for (int i = 0; i < 32; i++) release_slot(i);
    expect_pools("R8 all released", 0, 0, 65536, 65536);
  endtask

  task automatic t_hol;
    push(32, 1, 60000);
    push(32, 1, 8000);
    push(32, 1, 100);
    idle(2);
    chk("R7 stalled blocks", int'(act_blocks), 1);
    chk("R7 queue", int'(q_count), 2);
    push(32, 1, 100);
    push(32, 1, 100);
    chk("R11 full", int'(q_count), 4);
    chk("R11 ready low", int'(push_ready), 0);
    release_slot(0);
    chk("R9 head takes freed slot", last_slot, 0);
    idle(4);
    expect_pools("R3 after drain", 4, 4, 65536 - 8000 - 300, 65536 - 128);
    for (int i = 0; i < 4; i++) release_slot(i);
  endtask

  task automatic t_regs;
    push(256, 255, 0);
    push(32, 10, 0);
    idle(2);
    chk("R4 reg stall queue", int'(q_count), 1);
    chk("R4 reg free", int'(free_regs), 256);
    release_slot(0);
    chk("R9 slot", last_slot, 0);
    expect_pools("R4 after", 1, 1, 65536, 65536 - 320);
    release_slot(0);
  endtask

  task automatic t_ooo;
    push(64, 8, 1000);
    push(96, 16, 3000);
    push(32, 4, 500);
    idle(2);
    release_slot(1);
    expect_pools("R8 middle release", 2, 3, 65536 - 1500, 65536 - 640);
    release_slot(1);
    expect_pools("R8 inactive ignored", 2, 3, 65536 - 1500, 65536 - 640);
    release_slot(2);
    release_slot(0);
    expect_pools("R8 out of order", 0, 0, 65536, 65536);
  endtask

  task automatic t_warps;
    push(1024, 1, 0);
    push(1024, 1, 0);
    push(32, 1, 0);
    idle(2);
    chk("R2 warp cap", int'(act_warps), 64);
    chk("R2 waiting", int'(q_count), 1);
    release_slot(1);
    chk("R2 readmit slot", last_slot, 1);
    chk("R2 warps after", int'(act_warps), 33);
    release_slot(0);
    release_slot(1);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset;
    t_basic;
    t_round;
    t_reject;
    t_blocks;
    t_hol;
    t_regs;
    t_ooo;
    t_warps;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule